// File: doc/BRIEF.md
# Atomic Read-Modify-Write Request Interface

This block is the initiator-side adapter between one bus master and a request/response network that leads to a shared on-chip memory. It takes one command at a time: a read, a posted write, a non-posted write, or an exclusive read. It turns each command into typed request packets and sends the result back to the master as a single-cycle response pulse.

An exclusive read starts an atomic read-modify-write. The interface first sends a lock packet, which claims the path to the target. It then sends a load packet for the addressed word and returns the load data to the master. While the lock is held, the interface accepts nothing from its master except one write of either kind. That write sends a store packet carrying the modified word and then an unlock packet, which frees the target for other initiators. Plain reads and writes outside such a sequence map to one load or one store packet.

Every packet is held unchanged until the network takes it. Reset drops any lock the interface holds and leaves it idle, with no packet pending.

Top module: `lock_rmw_ni`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, pkt_valid_o and rsp_valid_o are 0, and cmd_ready_o is 1 for a read command (op 00).
- R2: An exclusive read (op 10) sends a packet of type 10 (lock), then a packet of type 00 (load), both carrying the command address. The load data returned on the network appears on rsp_data_o, with rsp_valid_o high, one cycle after net_rsp_valid_i.
- R3: While pkt_valid_o is high and pkt_ready_i is low, the packet's valid, type, address and data hold their values on the next cycle.
- R4: From the lock packet until the unlock packet has been taken, cmd_ready_o stays low for read (op 00) and exclusive-read (op 10) commands. No packet is sent while such a command waits.
- R5: After an exclusive read, the next write accepted is the closing write, either posted (op 01) or non-posted (op 11). It sends a store packet (type 01) with its write data, then an unlock packet (type 11) as the very next packet.
- R6: A posted write (op 01) raises rsp_valid_o on the cycle after the command is accepted.
- R7: A non-posted write (op 11) raises rsp_valid_o only one cycle after the store's response arrives on net_rsp_valid_i, and never before it. In a locked sequence, the unlock packet follows that response.
- R8: A read (op 00) outside a locked sequence sends exactly one load packet and no lock or unlock. It returns net_rsp_data_i on rsp_data_o one cycle after net_rsp_valid_i.
- R9: A write (op 01 or 11) outside a locked sequence sends exactly one store packet, with the command address and data, and no unlock.
- R10: Every packet carries the initiator identifier INIT_ID on pkt_src_o.
- R11: A reset applied while a lock is held returns the interface to idle. After reset, no unlock or other packet is sent, and a read command is accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Master command valid |
| cmd_op_i | input | 2 | Command: 00 read, 01 posted write, 10 exclusive read, 11 non-posted write |
| cmd_addr_i | input | ADDR_W | Command word address |
| cmd_wdata_i | input | DATA_W | Command write data |
| cmd_ready_o | output | 1 | Command accepted this cycle when high with cmd_valid_i |
| rsp_valid_o | output | 1 | One-cycle response pulse to the master |
| rsp_data_o | output | DATA_W | Read data for the response (0 for writes) |
| pkt_valid_o | output | 1 | Request packet valid |
| pkt_ready_i | input | 1 | Network takes the packet |
| pkt_type_o | output | 2 | 00 load, 01 store, 10 lock, 11 unlock |
| pkt_src_o | output | ID_W | Initiator identifier |
| pkt_addr_o | output | ADDR_W | Packet address |
| pkt_data_o | output | DATA_W | Store data (0 for other types) |
| net_rsp_valid_i | input | 1 | Response packet from target valid |
| net_rsp_data_i | input | DATA_W | Response packet data |

## Verification
The first packet of a command is due on the cycle after the command is accepted. Each later packet is due on the cycle after the previous one is taken. A response to the master is due one cycle after its cause: the network response for reads and non-posted writes, or the command acceptance for posted writes. The bench drives and samples on falling edges, so each value is read exactly one rising edge after the event that caused it. The bench stalls pkt_ready_i for random lengths to show that packets hold steady. During the windows before a response falls due, it checks that rsp_valid_o is still low.

// File: rtl/lock_rmw_pkg.sv
package lock_rmw_pkg;
  typedef enum logic [1:0] {
    OP_READ     = 2'b00,
    OP_WRITE    = 2'b01,
    OP_READ_EX  = 2'b10,
    OP_WRITE_NP = 2'b11
  } cmd_op_e;

  typedef enum logic [1:0] {
    PKT_LOAD   = 2'b00,
    PKT_STORE  = 2'b01,
    PKT_LOCK   = 2'b10,
    PKT_UNLOCK = 2'b11
  } pkt_type_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND_LOCK,
    ST_SEND_LOAD,
    ST_WAIT_RDATA,
    ST_LOCKED,
    ST_SEND_STORE,
    ST_SEND_UNLOCK
  } seq_state_e;

  function automatic logic op_is_write(input logic [1:0] op);
    return op[0];
  endfunction
endpackage

// File: rtl/lock_rmw_seq.sv
module lock_rmw_seq
  import lock_rmw_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic [1:0] cmd_op_i,
  input  logic       pkt_ready_i,
  input  logic       net_rsp_valid_i,
  output seq_state_e state_o,
  output logic       cmd_ready_o,
  output logic       cmd_accept_o,
  output logic       pkt_valid_o,
  output logic       rsp_fire_o,
  output logic       rsp_is_read_o
);
  seq_state_e state_q, state_d;
  logic lock_q, lock_d;
  logic np_q, np_d;
  logic ack_wait_q, ack_wait_d;
  logic pkt_fire;

  always_comb begin
    unique case (state_q)
      ST_IDLE:   cmd_ready_o = 1'b1;
      ST_LOCKED: cmd_ready_o = op_is_write(cmd_op_i);
      default:   cmd_ready_o = 1'b0;
    endcase
  end

  assign cmd_accept_o = cmd_valid_i && cmd_ready_o;
  assign pkt_valid_o  = (state_q == ST_SEND_LOCK) || (state_q == ST_SEND_LOAD) ||
                        (state_q == ST_SEND_STORE) || (state_q == ST_SEND_UNLOCK);
  assign pkt_fire     = pkt_valid_o && pkt_ready_i;

  // posted write answers on acceptance, everything else on network response
  assign rsp_fire_o    = (cmd_accept_o && cmd_op_i == OP_WRITE) ||
                         (state_q == ST_WAIT_RDATA && net_rsp_valid_i);
  assign rsp_is_read_o = (state_q == ST_WAIT_RDATA) && !ack_wait_q;

  always_comb begin
    state_d    = state_q;
    lock_d     = lock_q;
    np_d       = np_q;
    ack_wait_d = ack_wait_q;
    unique case (state_q)
      ST_IDLE: if (cmd_accept_o) begin
        unique case (cmd_op_i)
          OP_READ:    state_d = ST_SEND_LOAD;
          OP_READ_EX: begin state_d = ST_SEND_LOCK; lock_d = 1'b1; end
          default:    begin state_d = ST_SEND_STORE; np_d = (cmd_op_i == OP_WRITE_NP); end
        endcase
      end
      ST_LOCKED: if (cmd_accept_o) begin
        state_d = ST_SEND_STORE;
        np_d    = (cmd_op_i == OP_WRITE_NP);
      end
      ST_SEND_LOCK: if (pkt_fire) state_d = ST_SEND_LOAD;
      ST_SEND_LOAD: if (pkt_fire) begin
        state_d    = ST_WAIT_RDATA;
        ack_wait_d = 1'b0;
      end
      ST_SEND_STORE: if (pkt_fire) begin
        if (np_q) begin
          state_d    = ST_WAIT_RDATA;
          ack_wait_d = 1'b1;
        end else begin
          state_d = lock_q ? ST_SEND_UNLOCK : ST_IDLE;
        end
      end
      ST_WAIT_RDATA: if (net_rsp_valid_i) begin
        if (ack_wait_q) state_d = lock_q ? ST_SEND_UNLOCK : ST_IDLE;
        else            state_d = lock_q ? ST_LOCKED : ST_IDLE;
      end
      ST_SEND_UNLOCK: if (pkt_fire) begin
        state_d = ST_IDLE;
        lock_d  = 1'b0;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      lock_q     <= 1'b0;
      np_q       <= 1'b0;
      ack_wait_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      lock_q     <= lock_d;
      np_q       <= np_d;
      ack_wait_q <= ack_wait_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/lock_rmw_pkt_fmt.sv
module lock_rmw_pkt_fmt
  import lock_rmw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_accept_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_wdata_i,
  input  seq_state_e        state_i,
  output logic [1:0]        pkt_type_o,
  output logic [ADDR_W-1:0] pkt_addr_o,
  output logic [DATA_W-1:0] pkt_data_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (cmd_accept_i) begin
      addr_q  <= cmd_addr_i;
      wdata_q <= cmd_wdata_i;
    end
  end

  always_comb begin
    unique case (state_i)
      ST_SEND_LOCK:   pkt_type_o = PKT_LOCK;
      ST_SEND_STORE:  pkt_type_o = PKT_STORE;
      ST_SEND_UNLOCK: pkt_type_o = PKT_UNLOCK;
      default:        pkt_type_o = PKT_LOAD;
    endcase
  end

  assign pkt_addr_o = addr_q;
  assign pkt_data_o = (state_i == ST_SEND_STORE) ? wdata_q : '0;
endmodule

// File: rtl/lock_rmw_rsp.sv
module lock_rmw_rsp #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rsp_fire_i,
  input  logic              rsp_is_read_i,
  input  logic [DATA_W-1:0] net_rsp_data_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= rsp_fire_i;
      if (rsp_fire_i) rsp_data_o <= rsp_is_read_i ? net_rsp_data_i : '0;
    end
  end
endmodule

// File: rtl/lock_rmw_ni.sv
module lock_rmw_ni
  import lock_rmw_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int ID_W    = 4,
  parameter int INIT_ID = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_wdata_i,
  output logic              cmd_ready_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              pkt_valid_o,
  input  logic              pkt_ready_i,
  output logic [1:0]        pkt_type_o,
  output logic [ID_W-1:0]   pkt_src_o,
  output logic [ADDR_W-1:0] pkt_addr_o,
  output logic [DATA_W-1:0] pkt_data_o,
  input  logic              net_rsp_valid_i,
  input  logic [DATA_W-1:0] net_rsp_data_i
);
  localparam logic [ID_W-1:0] SRC_ID = ID_W'(INIT_ID);

  seq_state_e state;
  logic cmd_accept, rsp_fire, rsp_is_read;

  lock_rmw_seq u_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cmd_valid_i    (cmd_valid_i),
    .cmd_op_i       (cmd_op_i),
    .pkt_ready_i    (pkt_ready_i),
    .net_rsp_valid_i(net_rsp_valid_i),
    .state_o        (state),
    .cmd_ready_o    (cmd_ready_o),
    .cmd_accept_o   (cmd_accept),
    .pkt_valid_o    (pkt_valid_o),
    .rsp_fire_o     (rsp_fire),
    .rsp_is_read_o  (rsp_is_read)
  );

  lock_rmw_pkt_fmt #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fmt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_accept_i(cmd_accept),
    .cmd_addr_i  (cmd_addr_i),
    .cmd_wdata_i (cmd_wdata_i),
    .state_i     (state),
    .pkt_type_o  (pkt_type_o),
    .pkt_addr_o  (pkt_addr_o),
    .pkt_data_o  (pkt_data_o)
  );

  lock_rmw_rsp #(.DATA_W(DATA_W)) u_rsp (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .rsp_fire_i    (rsp_fire),
    .rsp_is_read_i (rsp_is_read),
    .net_rsp_data_i(net_rsp_data_i),
    .rsp_valid_o   (rsp_valid_o),
    .rsp_data_o    (rsp_data_o)
  );

  assign pkt_src_o = SRC_ID;
endmodule

// File: rtl/lock_rmw_ni_chk.sv
module lock_rmw_ni_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic [1:0]        cmd_op_i,
  input logic              cmd_ready_o,
  input logic              rsp_valid_o,
  input logic              pkt_valid_o,
  input logic              pkt_ready_i,
  input logic [1:0]        pkt_type_o,
  input logic [ADDR_W-1:0] pkt_addr_o,
  input logic [DATA_W-1:0] pkt_data_o,
  input logic              net_rsp_valid_i
);
  logic fire;
  logic lock_seen_q, want_unlock_q;

  assign fire = pkt_valid_o && pkt_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_seen_q   <= 1'b0;
      want_unlock_q <= 1'b0;
    end else begin
      if (fire && pkt_type_o == 2'b10) lock_seen_q <= 1'b1;
      if (fire && pkt_type_o == 2'b01 && lock_seen_q) want_unlock_q <= 1'b1;
      if (fire && pkt_type_o == 2'b11) begin
        lock_seen_q   <= 1'b0;
        want_unlock_q <= 1'b0;
      end
    end
  end

  p_pkt_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o && !pkt_ready_i |=> pkt_valid_o && $stable(pkt_type_o) &&
                                    $stable(pkt_addr_o) && $stable(pkt_data_o));

  p_lock_then_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && pkt_type_o == 2'b10 |=> pkt_valid_o && pkt_type_o == 2'b00);

  p_no_read_locked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_seen_q && cmd_valid_i && !cmd_op_i[0] |-> !cmd_ready_o);

  p_unlock_follows_store_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    want_unlock_q && pkt_valid_o |-> pkt_type_o == 2'b11);

  p_no_stray_unlock_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_seen_q && pkt_valid_o |-> pkt_type_o != 2'b11);

  p_posted_rsp_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_ready_o && cmd_op_i == 2'b01 |=> rsp_valid_o);

  p_rsp_has_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(net_rsp_valid_i) ||
                    $past(cmd_valid_i && cmd_ready_o && cmd_op_i == 2'b01));
endmodule

bind lock_rmw_ni lock_rmw_ni_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cmd_valid_i    (cmd_valid_i),
  .cmd_op_i       (cmd_op_i),
  .cmd_ready_o    (cmd_ready_o),
  .rsp_valid_o    (rsp_valid_o),
  .pkt_valid_o    (pkt_valid_o),
  .pkt_ready_i    (pkt_ready_i),
  .pkt_type_o     (pkt_type_o),
  .pkt_addr_o     (pkt_addr_o),
  .pkt_data_o     (pkt_data_o),
  .net_rsp_valid_i(net_rsp_valid_i)
);

// File: tb/lock_rmw_ni_tb.sv
`timescale 1ns/1ps
module lock_rmw_ni_tb;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int IW = 4;
  localparam int ID = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic cmd_ready, rsp_valid, pkt_valid;
  logic [DW-1:0] rsp_data, pkt_data;
  logic pkt_ready = 1'b0;
  logic [1:0] pkt_type;
  logic [IW-1:0] pkt_src;
  logic [AW-1:0] pkt_addr;
  logic net_valid = 1'b0;
  logic [DW-1:0] net_data = '0;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lock_rmw_ni #(.ADDR_W(AW), .DATA_W(DW), .ID_W(IW), .INIT_ID(ID)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_addr_i(cmd_addr),
    .cmd_wdata_i(cmd_wdata), .cmd_ready_o(cmd_ready),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .pkt_valid_o(pkt_valid), .pkt_ready_i(pkt_ready), .pkt_type_o(pkt_type),
    .pkt_src_o(pkt_src), .pkt_addr_o(pkt_addr), .pkt_data_o(pkt_data),
    .net_rsp_valid_i(net_valid), .net_rsp_data_i(net_data)
  );

  function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h1357_9bdf;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
    #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // at a falling edge: check packet, stall, then hand it over
  task automatic take_pkt(input logic [1:0] et, input logic [AW-1:0] ea,
                          input logic [DW-1:0] ed, input int stall, input string tag);
    chk(pkt_valid == 1'b1, {tag, " valid"}, pkt_valid, 1);
    chk(pkt_type == et, {tag, " type"}, pkt_type, et);
    chk(pkt_addr == ea, {tag, " addr"}, pkt_addr, ea);
    chk(pkt_src == IW'(ID), "R10 src", pkt_src, ID);
    if (et == 2'b01) chk(pkt_data == ed, {tag, " data"}, pkt_data, ed);
    for (int i = 0; i < stall; i++) begin
      pkt_ready = 1'b0;
      @(negedge clk);
      chk(pkt_valid && pkt_type == et && pkt_addr == ea, "R3 hold", {pkt_type, pkt_addr}, {et, ea});
    end
    pkt_ready = 1'b1;
    @(negedge clk);
    pkt_ready = 1'b0;
  endtask

  task automatic reply(input logic [DW-1:0] d, input logic [DW-1:0] exp, input bit is_read, input string tag);
    chk(rsp_valid == 1'b0, {tag, " early rsp"}, rsp_valid, 0);
    net_valid = 1'b1; net_data = d;
    @(negedge clk);
    net_valid = 1'b0; net_data = '0;
    chk(rsp_valid == 1'b1, {tag, " rsp"}, rsp_valid, 1);
    if (is_read) chk(rsp_data == exp, {tag, " rdata"}, rsp_data, exp);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input int st);
    issue(2'b00, a, '0);
    take_pkt(2'b00, a, '0, st, "R8 load");
    chk(pkt_valid == 1'b0, "R8 single", pkt_valid, 0);
    repeat (st) @(negedge clk);
    reply(mem_val(a), mem_val(a), 1, "R8");
  endtask

  task automatic do_write(input bit np, input logic [AW-1:0] a, input logic [DW-1:0] d, input int st);
    issue(np ? 2'b11 : 2'b01, a, d);
    if (!np) chk(rsp_valid == 1'b1, "R6 posted rsp", rsp_valid, 1);
    take_pkt(2'b01, a, d, st, "R9 store");
    chk(pkt_valid == 1'b0, "R9 single", pkt_valid, 0);
    if (np) begin
      repeat (st) begin @(negedge clk); chk(rsp_valid == 1'b0, "R7 wait", rsp_valid, 0); end
      reply(32'h0, 32'h0, 0, "R7");
      chk(pkt_valid == 1'b0, "R9 no unlock", pkt_valid, 0);
    end
  endtask

  task automatic do_rmw(input bit np, input logic [AW-1:0] a, input logic [AW-1:0] wa,
                        input logic [DW-1:0] d, input int st, input bit probe);
    issue(2'b10, a, '0);
    take_pkt(2'b10, a, '0, st, "R2 lock");
    take_pkt(2'b00, a, '0, st, "R2 load");
    reply(mem_val(a), mem_val(a), 1, "R2");
    if (probe) begin
      cmd_valid = 1'b1; cmd_op = (st % 2 == 0) ? 2'b00 : 2'b10; cmd_addr = wa;
      for (int i = 0; i < 3; i++) begin
        #1;
        chk(cmd_ready == 1'b0, "R4 held", cmd_ready, 0);
        chk(pkt_valid == 1'b0, "R4 no pkt", pkt_valid, 0);
        @(negedge clk);
      end
      cmd_valid = 1'b0;
    end
    issue(np ? 2'b11 : 2'b01, wa, d);
    if (!np) chk(rsp_valid == 1'b1, "R6 posted rsp", rsp_valid, 1);
    take_pkt(2'b01, wa, d, st, "R5 store");
    if (np) begin
      chk(pkt_valid == 1'b0, "R7 unlock waits", pkt_valid, 0);
      reply(32'h0, 32'h0, 0, "R7");
    end
    take_pkt(2'b11, wa, '0, st, "R5 unlock");
    chk(pkt_valid == 1'b0, "R5 end", pkt_valid, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(pkt_valid == 1'b0, "R1 pkt in reset", pkt_valid, 0);
    chk(rsp_valid == 1'b0, "R1 rsp in reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pkt_valid == 1'b0 && rsp_valid == 1'b0, "R1 after reset", {pkt_valid, rsp_valid}, 0);
    chk(cmd_ready == 1'b1, "R1 ready", cmd_ready, 1);

    do_read(32'h0000_0010, 0);
    do_write(0, 32'h0000_0020, 32'hdead_beef, 2);
    do_write(1, 32'h0000_0030, 32'hcafe_f00d, 3);
    do_rmw(0, 32'h0000_0040, 32'h0000_0040, 32'h1111_2222, 0, 1);
    do_rmw(1, 32'h0000_0050, 32'h0000_0050, 32'h3333_4444, 3, 1);

    // R11: reset while locked
    issue(2'b10, 32'h0000_0060, '0);
    take_pkt(2'b10, 32'h0000_0060, '0, 1, "R2 lock");
    take_pkt(2'b00, 32'h0000_0060, '0, 0, "R2 load");
    reply(mem_val(32'h60), mem_val(32'h60), 1, "R2");
    rst_n = 1'b0;
    @(negedge clk);
    chk(pkt_valid == 1'b0, "R11 pkt in reset", pkt_valid, 0);
    rst_n = 1'b1;
    cmd_op = 2'b00;
    #1;
    chk(cmd_ready == 1'b1, "R11 read accepted", cmd_ready, 1);
    repeat (3) begin @(negedge clk); chk(pkt_valid == 1'b0, "R11 no unlock", pkt_valid, 0); end
    do_read(32'h0000_0070, 1);

    for (int n = 0; n < 60; n++) begin
      int kind = $urandom_range(0, 4);
      int st = $urandom_range(0, 3);
      logic [AW-1:0] a = $urandom;
      logic [DW-1:0] d = $urandom;
      case (kind)
        0: do_read(a, st);
        1: do_write(0, a, d, st);
        2: do_write(1, a, d, st);
        3: do_rmw(0, a, a ^ 32'h4, d, st, $urandom_range(0, 1) == 1);
        default: do_rmw(1, a, a, d, st, $urandom_range(0, 1) == 1);
      endcase
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule